// File: doc/BRIEF.md
# Serial Binary-to-BCD Converter

This block converts an unsigned binary word into packed binary-coded-decimal digits. It handles one binary bit per clock. A one-cycle `start` pulse, taken while the block is idle, captures the operand and clears the digit register. The operand then moves into the digits most significant bit first. A one-cycle `done` pulse marks the cycle in which the digits first hold the finished result.

Each step is a decimal-aware left shift. Every 4-bit digit doubles its value and adds the bit shifted in from below. If the result is ten or more, ten is subtracted and a carry of one goes into the next digit up. Each digit's correction depends only on its own old value and on one bit from its lower neighbour. No carry travels further than one digit in a cycle, so widening the word adds neither logic depth nor clock-rate penalty. The input width `BIN_W` and the digit count `DIG_N` are parameters.

The controller is a three-state machine:
- IDLE waits for `start`.
- SHIFT performs `BIN_W` shifts.
- DONE raises `done` for one cycle and then returns to IDLE.

The transitions are:
- IDLE→SHIFT on `start`, named *accept*.
- SHIFT→SHIFT while shifts remain, named *step*.
- SHIFT→DONE on the last shift, named *finish*.
- DONE→IDLE unconditionally, named *release*.

Top module: `bin2bcd_serial`

## Requirements
- R1: With the default parameters, the block takes a 16-bit operand and produces 5 digits. Digit i sits in `bcd_out[4*i+3:4*i]`, and digit 0 is the least significant.
- R2: When `done` is high, `bcd_out` equals the decimal value of the captured operand modulo 10^DIG_N, and every digit is in the range 0 to 9.
- R3: A `start` sampled high while `busy` is low captures `bin_in` and clears the digit register. `busy` is high on the following cycle.
- R4: `done` goes high in the cycle that follows the BIN_W-th rising edge after the capturing edge. That is BIN_W+1 cycles after the cycle in which `start` was driven.
- R5: After `done`, `bcd_out` holds its value until the next accepted `start`.
- R6: `done` is high for exactly one cycle per conversion.
- R7: A `start` that arrives while `busy` is high is ignored. This includes the `done` cycle. Such a `start` changes neither the result nor the timing of the running conversion, and it does not begin a new one.
- R8: The operand is shifted MSB first into the LSB of digit 0. On each shift a digit d that receives bit c becomes 2d+c, or 2d+c−10 with a carry of one into the next digit when 2d+c ≥ 10.
- R9: `busy` is high from the cycle after the capturing edge through the `done` cycle, and low otherwise. An active-low `rst_n` forces `busy`, `done` and `bcd_out` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion when idle |
| bin_in | input | BIN_W | Unsigned binary operand, sampled with start |
| busy | output | 1 | Conversion in progress, including the done cycle |
| done | output | 1 | One-cycle pulse: result valid |
| bcd_out | output | 4*DIG_N | Packed BCD result, digit 0 in the low nibble |

## Verification
Two functions can fall in the same cycle: the completion pulse of one conversion and the `start` request for the next. The bench drives `start` high with a new operand in the very cycle in which it sees `done`. It then expects the block to report not busy on the next cycle, still holding the old result. A second `start` in the idle cycle that follows must then be accepted with normal latency. A further `start` pulse in the middle of the shift phase must leave both the result and the BIN_W+1-cycle latency of the running conversion unchanged.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } conv_state_t;

    localparam int DIGIT_BITS = 4;

endpackage

// File: rtl/bcd_digit_cell.sv
// One decimal digit of the shift chain: doubles the digit, adds the bit
// arriving from below, and folds values of ten or more back into range.
module bcd_digit_cell
    import bcd_conv_pkg::*;
(
    input  logic [DIGIT_BITS-1:0] dig_in,
    input  logic                  bit_in,
    output logic [DIGIT_BITS-1:0] dig_out,
    output logic                  bit_out
);
    logic [DIGIT_BITS:0] doubled;

    always_comb begin
        doubled = {dig_in, bit_in};
        if (doubled >= (DIGIT_BITS+1)'(10)) begin
            dig_out = DIGIT_BITS'(doubled - (DIGIT_BITS+1)'(10));
            bit_out = 1'b1;
        end else begin
            dig_out = doubled[DIGIT_BITS-1:0];
            bit_out = 1'b0;
        end
    end
endmodule

// File: rtl/bcd_shift_chain.sv
// A row of digit cells; each carry reaches only its upper neighbour.
module bcd_shift_chain
    import bcd_conv_pkg::*;
#(
    parameter int DIG_N = 5
) (
    input  logic [DIGIT_BITS*DIG_N-1:0] cur_digits,
    input  logic                        ser_bit,
    output logic [DIGIT_BITS*DIG_N-1:0] nxt_digits,
    output logic                        overflow_bit
);
    logic [DIG_N:0] link;

    assign link[0]      = ser_bit;
    assign overflow_bit = link[DIG_N];

    for (genvar g = 0; g < DIG_N; g++) begin : g_cell
        bcd_digit_cell u_cell (
            .dig_in  (cur_digits[DIGIT_BITS*g +: DIGIT_BITS]),
            .bit_in  (link[g]),
            .dig_out (nxt_digits[DIGIT_BITS*g +: DIGIT_BITS]),
            .bit_out (link[g+1])
        );
    end
endmodule

// File: rtl/bin2bcd_serial.sv
module bin2bcd_serial
    import bcd_conv_pkg::*;
#(
    parameter int BIN_W = 16,
    parameter int DIG_N = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [BIN_W-1:0]            bin_in,
    output logic                        busy,
    output logic                        done,
    output logic [DIGIT_BITS*DIG_N-1:0] bcd_out
);
    localparam int BCD_W = DIGIT_BITS * DIG_N;
    localparam int CNT_W = $clog2(BIN_W + 1);

    conv_state_t       state_q, state_d;
    logic [BIN_W-1:0]  opnd_q;
    logic [BCD_W-1:0]  bcd_q, bcd_nx;
    logic [CNT_W-1:0]  cnt_q;
    logic              accept, last_step, ovf_unused;

    assign accept    = (state_q == ST_IDLE) && start;
    assign last_step = (cnt_q == CNT_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)     state_d = ST_SHIFT; // accept
            ST_SHIFT: if (last_step) state_d = ST_DONE;  // finish, else step
            ST_DONE:                 state_d = ST_IDLE;  // release
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_DONE);
        bcd_out = bcd_q;
    end

    bcd_shift_chain #(.DIG_N(DIG_N)) u_chain (
        .cur_digits   (bcd_q),
        .ser_bit      (opnd_q[BIN_W-1]),
        .nxt_digits   (bcd_nx),
        .overflow_bit (ovf_unused)
    );

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opnd_q <= '0;
            bcd_q  <= '0;
            cnt_q  <= '0;
        end else if (accept) begin
            opnd_q <= bin_in;
            bcd_q  <= '0;
            cnt_q  <= CNT_W'(BIN_W);
        end else if (state_q == ST_SHIFT) begin
            opnd_q <= opnd_q << 1;
            bcd_q  <= bcd_nx;
            cnt_q  <= cnt_q - CNT_W'(1);
        end
    end

    // R6: completion is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: an accepted start makes the block busy without completing at once
    a_r3_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done));

    // R5: result is stable while idle and no start arrives
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(bcd_out));

    // R7: a start during the done cycle does not restart the engine
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !busy);

    // R2: every stored digit stays a legal decimal digit
    for (genvar g = 0; g < DIG_N; g++) begin : g_dig_chk
        a_r2_digit_legal: assert property (@(posedge clk) disable iff (!rst_n)
            bcd_q[DIGIT_BITS*g +: DIGIT_BITS] <= DIGIT_BITS'(9));
    end
endmodule

// File: tb/sim_bin2bcd_serial.sv
`timescale 1ns/1ps
module sim_bin2bcd_serial;
    localparam int W = 16;
    localparam int D = 5;
    localparam int NV = 13;
    localparam logic [W-1:0]   VEC_IN  [NV] = '{16'd0, 16'd1, 16'd9, 16'd10,
        16'd99, 16'd100, 16'd999, 16'd1000, 16'd4096, 16'd9999, 16'd10000,
        16'd12345, 16'd65535};
    localparam logic [4*D-1:0] VEC_EXP [NV] = '{20'h00000, 20'h00001,
        20'h00009, 20'h00010, 20'h00099, 20'h00100, 20'h00999, 20'h01000,
        20'h04096, 20'h09999, 20'h10000, 20'h12345, 20'h65535};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] bin_in = '0;
    logic busy, done;
    logic [4*D-1:0] bcd_out;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bin2bcd_serial #(.BIN_W(W), .DIG_N(D)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .bin_in(bin_in),
        .busy(busy), .done(done), .bcd_out(bcd_out));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [4*D-1:0] ref_bcd(input logic [W-1:0] v);
        int unsigned x = v;
        logic [4*D-1:0] r = '0;
        for (int i = 0; i < D; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    // start at a negedge, wait for done, return cycles counted
    task automatic launch_wait(input logic [W-1:0] v, input int poke_at,
                               input logic [W-1:0] poke_v, output int n);
        @(negedge clk); start = 1'b1; bin_in = v;
        @(negedge clk); start = 1'b0; bin_in = ~v;
        n = 1;
        while (!done && n < 40) begin
            if (n == poke_at) begin start = 1'b1; bin_in = poke_v; end
            @(negedge clk);
            start = 1'b0;
            n++;
        end
    endtask

    task automatic conv(input logic [W-1:0] v, input logic [4*D-1:0] exp,
                        input string req);
        int n;
        launch_wait(v, -1, '0, n);
        chk(done === 1'b1 && n == W + 1, "R4", "latency", 32'(n), 32'(W + 1));
        chk(bcd_out === exp, req, "result", 32'(bcd_out), 32'(exp));
        @(negedge clk);
        chk(done === 1'b0, "R6", "done width", 32'(done), 32'd0);
        chk(busy === 1'b0, "R9", "busy after done", 32'(busy), 32'd0);
        chk(bcd_out === exp, "R5", "hold", 32'(bcd_out), 32'(exp));
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        #3;
        chk(busy === 1'b0 && done === 1'b0, "R9", "reset flags",
            32'({busy, done}), 32'd0);
        chk(bcd_out === '0, "R9", "reset bcd", 32'(bcd_out), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // vector table (R1 field layout, R8 carries such as 9999)
        for (int i = 0; i < NV; i++)
            conv(VEC_IN[i], VEC_EXP[i], (i == 9) ? "R8" : "R1");

        // R3: busy on the cycle after accept
        @(negedge clk); start = 1'b1; bin_in = 16'd321;
        @(negedge clk); start = 1'b0;
        chk(busy === 1'b1, "R3", "busy after accept", 32'(busy), 32'd1);
        while (!done) @(negedge clk);
        chk(bcd_out === 20'h00321, "R3", "result", 32'(bcd_out), 32'h321);
        @(negedge clk);

        // R3: clearing on start - zero after a large value
        conv(16'd65535, 20'h65535, "R2");
        conv(16'd0, 20'h00000, "R3");

        // R7: start pulse mid-shift is ignored
        launch_wait(16'd4321, 6, 16'd7777, n);
        chk(n == W + 1, "R7", "latency with mid start", 32'(n), 32'(W + 1));
        chk(bcd_out === 20'h04321, "R7", "result with mid start",
            32'(bcd_out), 32'h04321);

        // R7: start in the done cycle is ignored, then an idle start works
        start = 1'b1; bin_in = 16'd55555;
        @(negedge clk); start = 1'b0;
        chk(busy === 1'b0, "R7", "no restart from done cycle", 32'(busy), 32'd0);
        chk(bcd_out === 20'h04321, "R7", "held after done-cycle start",
            32'(bcd_out), 32'h04321);
        repeat (4) @(negedge clk);
        chk(bcd_out === 20'h04321, "R5", "hold over idle", 32'(bcd_out), 32'h04321);
        conv(16'd55555, 20'h55555, "R3");

        // R9: reset mid-conversion
        @(negedge clk); start = 1'b1; bin_in = 16'd8888;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(busy === 1'b0 && done === 1'b0 && bcd_out === '0, "R9",
            "mid reset", 32'({busy, done, bcd_out}), 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R2: sweep across the input range against division by ten
        for (int v = 0; v < 65536; v += 13)
            conv(16'(v), ref_bcd(16'(v)), "R2");
        conv(16'd65534, ref_bcd(16'd65534), "R2");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule